// File: doc/BRIEF.md
# CAN Controller Mode Register with Sleep and Bus-Free Sequencing

This block holds the byte-wide mode control register of a CAN protocol controller. It applies the rules on when each mode bit may change. It sequences the low-power sleep state and the wake-up that ends it. It also hosts the pin-level functions that depend on the mode. These are the receive polarity inverter, the test loop that copies the receive pin onto the transmit pin, and a bus-free detector that counts consecutive recessive bit samples.

The CPU writes and reads the register at offset 0 of a small register window. The protocol engine uses the decoded controls: reset, listen-only, self-test and test mode. It receives the polarity-corrected dominant level and a receive enable. It supplies a bit-sample strobe, the dominant/recessive bit it wants to transmit, and a bus-activity indication. The interrupt logic supplies a pending flag and receives a one-cycle wake-up interrupt pulse.

Top module: `canmode_ctl`

## Requirements
- R1: The register at address 0 reads, one cycle after the read address is presented, as {bit7 test, bit6 0, bit5 polarity, bit4 sleep, bit3 0, bit2 self-test, bit1 listen-only, bit0 reset}. Any other address reads 0. A write in the same cycle as a read does not affect that read.
- R2: A write to address 0 loads bits 1, 2, 5 and 7 only when the reset bit is already 1 before the write. Otherwise those bits keep their values. Bit 0 is always loaded from the write data.
- R3: After a synchronous reset, the reset bit is 1 and every other mode bit is 0. The mode outputs are registers and follow the register bits directly.
- R4: `abort` pulses for one cycle after a write that sets the reset bit while it was 0.
- R5: A write with bit 4 = 1 while awake sets the sleep bit only if all of the following hold: the reset bit is 0, bus-free has been seen (R9), `bus_act` is 0 and `irq_pend` is 0. If the first two hold but activity or a pending interrupt is present, the sleep bit stays 0 and `wake_irq` pulses instead.
- R6: While asleep, a write with bit 4 = 0 clears the sleep bit. So does `bus_act` = 1, which wins over a simultaneous write. Either event makes `wake_irq` pulse for exactly one cycle, even when both happen in the same cycle.
- R7: A wake caused by `bus_act` blocks reception until the bus-free counter, restarted at the wake, reaches its limit. `rx_enable` is 1 only when reception is not blocked, the reset bit is 0 and the block is awake.
- R8: On each `bit_stb`, the counter increments when `rx_dom` is 0 and clears when `rx_dom` is 1. It saturates at BF_BITS (default 11). `bus_free` is 1 exactly while the count equals BF_BITS.
- R9: A bus-free-seen flag is cleared while the reset bit is 1. It is set when `bus_free` is 1 while the reset bit is 0. A sleep request made while this flag is 0 is ignored, with no interrupt.
- R10: `rx_dom` is registered from `rx_pin`. It equals `rx_pin` when the polarity bit is 1 and the inverse of `rx_pin` when the polarity bit is 0.
- R11: `tx_pin` is registered. In test mode it equals `rx_pin` of the previous cycle, regardless of polarity. Otherwise it is 1 (recessive) when listen-only or reset is 1, and the inverse of `tx_bit_dom` in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read data |
| bit_stb | input | 1 | Receive bit-sample strobe from the engine |
| bus_act | input | 1 | Bus activity seen |
| irq_pend | input | 1 | Some controller interrupt is pending |
| tx_bit_dom | input | 1 | Engine transmit bit, 1 = dominant |
| rx_pin | input | 1 | Receive pin level |
| tx_pin | output | 1 | Transmit pin level |
| rx_dom | output | 1 | Polarity-corrected receive bit, 1 = dominant |
| mode_reset | output | 1 | Reset mode control |
| mode_listen | output | 1 | Listen-only control |
| mode_selftest | output | 1 | Self-test control |
| mode_test | output | 1 | Test-loop control |
| abort | output | 1 | Abort pulse on entering reset mode |
| sleeping | output | 1 | Sleep bit |
| wake_irq | output | 1 | Wake-up interrupt pulse |
| rx_enable | output | 1 | Reception allowed |
| bus_free | output | 1 | Bus-free count reached |

## Verification
Several pairs of events can land in the same cycle. The sharpest is a CPU write that clears the sleep bit in the cycle where `bus_act` also rises. The two wake causes must merge into a single `wake_irq` pulse, and reception must still be blocked because activity was involved. The bench drives this collision on purpose, and also a sleep request together with a pending interrupt. Its cycle model, which is built from the requirements, predicts the interrupt count, the sleep bit and `rx_enable` in every cycle that follows. Long random stretches also produce collisions between bit strobes, mode writes and activity.

// File: rtl/canmode_pkg.sv
package canmode_pkg;
  localparam int DATA_W = 8;
  localparam int B_RST  = 0;
  localparam int B_LSN  = 1;
  localparam int B_STST = 2;
  localparam int B_SLP  = 4;
  localparam int B_POL  = 5;
  localparam int B_TST  = 7;

  typedef struct packed {
    logic tst;
    logic pol;
    logic stst;
    logic lsn;
    logic rst;
  } mode_t;
endpackage

// File: rtl/canmode_reg.sv
module canmode_reg
  import canmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sleep_bit,
  output mode_t             mode,
  output logic [DATA_W-1:0] rdata,
  output logic              abort
);
  logic [DATA_W-1:0] view;

  always_comb begin
    view         = '0;
    view[B_RST]  = mode.rst;
    view[B_LSN]  = mode.lsn;
    view[B_STST] = mode.stst;
    view[B_SLP]  = sleep_bit;
    view[B_POL]  = mode.pol;
    view[B_TST]  = mode.tst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= '{tst: 1'b0, pol: 1'b0, stst: 1'b0, lsn: 1'b0, rst: 1'b1};
      rdata <= '0;
      abort <= 1'b0;
    end else begin
      rdata <= rd_sel ? view : '0;
      abort <= wr_en && wdata[B_RST] && !mode.rst;
      if (wr_en) begin
        mode.rst <= wdata[B_RST];
        if (mode.rst) begin
          mode.lsn  <= wdata[B_LSN];
          mode.stst <= wdata[B_STST];
          mode.pol  <= wdata[B_POL];
          mode.tst  <= wdata[B_TST];
        end
      end
    end
  end

  p_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode.rst) |=> (mode.lsn == $past(mode.lsn) && mode.tst == $past(mode.tst)
                              && mode.pol == $past(mode.pol) && mode.stst == $past(mode.stst)));

  p_resv_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_sel && (wdata[3] || wdata[6])) |=> ##1 (rdata[3] == 1'b0 && rdata[6] == 1'b0));

  p_abort_r4: assert property (@(posedge clk) disable iff (rst)
    abort |-> (mode.rst && !$past(mode.rst)));
endmodule

// File: rtl/canmode_busfree.sv
module canmode_busfree #(
  parameter int BF_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bit_stb,
  input  logic dom,
  output logic bus_free
);
  localparam int CW = $clog2(BF_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BF_BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (bit_stb) begin
      if (dom)              cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end

  assign bus_free = (cnt == LIMIT);

  p_cnt_max_r8: assert property (@(posedge clk) disable iff (rst) cnt <= LIMIT);

  p_dom_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && dom) |=> !bus_free);
endmodule

// File: rtl/canmode_sleep.sv
module canmode_sleep (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_sleep,
  input  logic rm,
  input  logic bus_act,
  input  logic irq_pend,
  input  logic bus_free,
  output logic sleep_bit,
  output logic wake_irq,
  output logic restart,
  output logic rx_block
);
  logic bf_seen;
  logic may_sleep;
  logic wake_cpu;
  logic refused;

  assign may_sleep = !rm && bf_seen;
  assign restart   = sleep_bit && bus_act;
  assign wake_cpu  = wr_en && sleep_bit && !wr_sleep;
  assign refused   = wr_en && !sleep_bit && wr_sleep && may_sleep && (bus_act || irq_pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_bit <= 1'b0;
      wake_irq  <= 1'b0;
      rx_block  <= 1'b0;
      bf_seen   <= 1'b0;
    end else begin
      wake_irq <= restart || wake_cpu || refused;
      if (restart)
        sleep_bit <= 1'b0;
      else if (wr_en) begin
        if (sleep_bit) sleep_bit <= wr_sleep;
        else           sleep_bit <= wr_sleep && may_sleep && !bus_act && !irq_pend;
      end
      if (restart)       rx_block <= 1'b1;
      else if (bus_free) rx_block <= 1'b0;
      if (rm)            bf_seen <= 1'b0;
      else if (bus_free) bf_seen <= 1'b1;
    end
  end

  p_sleep_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_bit) |-> ($past(!bus_act) && $past(!irq_pend) && $past(!rm)));

  p_wake_irq_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_bit) |-> wake_irq);

  p_block_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_block) |-> $past(bus_act));
endmodule

// File: rtl/canmode_pins.sv
module canmode_pins (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic tst,
  input  logic quiet,
  input  logic rx_pin,
  input  logic tx_bit_dom,
  output logic rx_dom,
  output logic tx_pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_dom <= 1'b0;
      tx_pin <= 1'b1;
    end else begin
      rx_dom <= pol ? rx_pin : !rx_pin;
      if (tst)        tx_pin <= rx_pin;
      else if (quiet) tx_pin <= 1'b1;
      else            tx_pin <= !tx_bit_dom;
    end
  end

  p_test_loop_r11: assert property (@(posedge clk) disable iff (rst)
    tst |=> (tx_pin == $past(rx_pin)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (quiet && !tst) |=> tx_pin);
endmodule

// File: rtl/canmode_ctl.sv
module canmode_ctl
  import canmode_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BF_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bit_stb,
  input  logic              bus_act,
  input  logic              irq_pend,
  input  logic              tx_bit_dom,
  input  logic              rx_pin,
  output logic              tx_pin,
  output logic              rx_dom,
  output logic              mode_reset,
  output logic              mode_listen,
  output logic              mode_selftest,
  output logic              mode_test,
  output logic              abort,
  output logic              sleeping,
  output logic              wake_irq,
  output logic              rx_enable,
  output logic              bus_free
);
  mode_t mode;
  logic  sel;
  logic  wr_en;
  logic  restart;
  logic  rx_block;

  assign sel   = (cpu_addr == '0);
  assign wr_en = cpu_we && sel;

  canmode_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_sel(sel), .wdata(cpu_wdata),
    .sleep_bit(sleeping), .mode(mode), .rdata(cpu_rdata), .abort(abort)
  );

  canmode_sleep u_sleep (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sleep(cpu_wdata[B_SLP]),
    .rm(mode.rst), .bus_act(bus_act), .irq_pend(irq_pend), .bus_free(bus_free),
    .sleep_bit(sleeping), .wake_irq(wake_irq), .restart(restart), .rx_block(rx_block)
  );

  canmode_busfree #(.BF_BITS(BF_BITS)) u_bf (
    .clk(clk), .rst(rst), .restart(restart), .bit_stb(bit_stb),
    .dom(rx_dom), .bus_free(bus_free)
  );

  canmode_pins u_pins (
    .clk(clk), .rst(rst), .pol(mode.pol), .tst(mode.tst),
    .quiet(mode.lsn || mode.rst), .rx_pin(rx_pin), .tx_bit_dom(tx_bit_dom),
    .rx_dom(rx_dom), .tx_pin(tx_pin)
  );

  assign mode_reset    = mode.rst;
  assign mode_listen   = mode.lsn;
  assign mode_selftest = mode.stst;
  assign mode_test     = mode.tst;
  assign rx_enable     = !rx_block && !mode.rst && !sleeping;

  p_rxen_r7: assert property (@(posedge clk) disable iff (rst)
    (sleeping && bus_act) |=> !rx_enable);
endmodule

// File: tb/sim_canmode_ctl.sv
module sim_canmode_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic bit_stb = 1'b0, bus_act = 1'b0, irq_pend = 1'b0, tx_bit_dom = 1'b0, rx_pin = 1'b1;
  logic tx_pin, rx_dom, mode_reset, mode_listen, mode_selftest, mode_test;
  logic abort, sleeping, wake_irq, rx_enable, bus_free;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  canmode_ctl u0 (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .bit_stb(bit_stb), .bus_act(bus_act), .irq_pend(irq_pend),
    .tx_bit_dom(tx_bit_dom), .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_dom(rx_dom),
    .mode_reset(mode_reset), .mode_listen(mode_listen), .mode_selftest(mode_selftest),
    .mode_test(mode_test), .abort(abort), .sleeping(sleeping), .wake_irq(wake_irq),
    .rx_enable(rx_enable), .bus_free(bus_free)
  );

  always #2.5 clk = ~clk;

  // reference model state
  bit m_rm = 1, m_lom = 0, m_stm = 0, m_pol = 0, m_tm = 0, m_slp = 0;
  bit m_abort = 0, m_wirq = 0, m_blk = 0, m_seen = 0, m_rxd = 0, m_tx = 1;
  int m_rd = 0;
  int m_cnt = 0;
  int wake_count = 0;

  always @(posedge clk) begin
    bit wr, may, wact, wcpu, refuse, bf;
    cycles++;
    if (rst) begin
      m_rm = 1; m_lom = 0; m_stm = 0; m_pol = 0; m_tm = 0; m_slp = 0;
      m_abort = 0; m_wirq = 0; m_blk = 0; m_seen = 0; m_rxd = 0; m_tx = 1;
      m_rd = 0; m_cnt = 0;
    end else begin
      wr     = cpu_we && (cpu_addr == 0);
      bf     = (m_cnt == 11);
      may    = !m_rm && m_seen;
      wact   = m_slp && bus_act;
      wcpu   = wr && m_slp && !cpu_wdata[4];
      refuse = wr && !m_slp && cpu_wdata[4] && may && (bus_act || irq_pend);
      m_rd   = (cpu_addr == 0) ? (m_tm * 128 + m_pol * 32 + m_slp * 16 + m_stm * 4 + m_lom * 2 + m_rm) : 0;
      m_tx   = m_tm ? rx_pin : ((m_lom || m_rm) ? 1'b1 : !tx_bit_dom);
      if (wact) m_cnt = 0;
      else if (bit_stb) m_cnt = m_rxd ? 0 : ((m_cnt < 11) ? m_cnt + 1 : 11);
      m_rxd  = m_pol ? rx_pin : !rx_pin;
      m_abort = wr && cpu_wdata[0] && !m_rm;
      m_wirq = wact || wcpu || refuse;
      if (m_wirq) wake_count++;
      if (wact) m_slp = 0;
      else if (wr) m_slp = m_slp ? cpu_wdata[4] : (cpu_wdata[4] && may && !bus_act && !irq_pend);
      if (wact) m_blk = 1; else if (bf) m_blk = 0;
      if (m_rm) m_seen = 0; else if (bf) m_seen = 1;
      if (wr) begin
        if (m_rm) begin
          m_lom = cpu_wdata[1]; m_stm = cpu_wdata[2]; m_pol = cpu_wdata[5]; m_tm = cpu_wdata[7];
        end
        m_rm = cpu_wdata[0];
      end
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, nm, cycles, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1", "cpu_rdata", cpu_rdata, m_rd);
    chk("R2", "mode_listen", mode_listen, m_lom);
    chk("R2", "mode_selftest", mode_selftest, m_stm);
    chk("R3", "mode_reset", mode_reset, m_rm);
    chk("R2", "mode_test", mode_test, m_tm);
    chk("R4", "abort", abort, m_abort);
    chk("R5", "sleeping", sleeping, m_slp);
    chk("R6", "wake_irq", wake_irq, m_wirq);
    chk("R7", "rx_enable", rx_enable, !m_blk && !m_rm && !m_slp);
    chk("R8", "bus_free", bus_free, m_cnt == 11);
    chk("R10", "rx_dom", rx_dom, m_rxd);
    chk("R11", "tx_pin", tx_pin, m_tx);
  endtask

  task automatic cyc(input bit we, input int a, input int wd, input bit stb,
                     input bit rx, input bit ba, input bit ip, input bit txb);
    @(negedge clk);
    if (!rst) compare();
    cpu_we = we; cpu_addr = 4'(a); cpu_wdata = 8'(wd);
    bit_stb = stb; rx_pin = rx; bus_act = ba; irq_pend = ip; tx_bit_dom = txb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic wr(input int d);
    cyc(1, 0, d, 0, 1, 0, 0, 0);
  endtask

  task automatic strobes(input int n, input bit rx);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, rx, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R3: reset values observed right after reset (compare runs each cycle)
    chk("R3", "reset read", cpu_rdata, 8'h01);
    // R2: writes inside reset mode land, reserved bits stay 0 (R1)
    wr(8'hFF); idle(2);
    wr(8'h49); idle(2);
    cyc(0, 3, 0, 0, 1, 0, 0, 0); idle(1);
    // leave reset mode, then gated write
    wr(8'h00); idle(1);
    wr(8'hA6); idle(2);
    // R9: sleep before bus-free seen is ignored
    wr(8'h10); idle(2);
    // R8: recessive bits, one dominant, more recessive
    strobes(5, 1); strobes(1, 0); strobes(13, 1); idle(2);
    // R5: sleep with pending interrupt refused; then accepted
    cyc(1, 0, 8'h10, 0, 1, 0, 1, 0); idle(2);
    wr(8'h10); idle(3);
    // R6/R7: bus activity wakes and blocks reception
    cyc(0, 0, 0, 0, 1, 1, 0, 0); idle(2);
    strobes(12, 1); idle(2);
    // R6: cpu clear and activity in the same cycle
    wr(8'h10); idle(2);
    cyc(1, 0, 8'h00, 0, 1, 1, 0, 0); idle(2);
    chk("R6", "single wake pulse count", wake_count, 3);
    strobes(12, 1);
    // R6: cpu wake alone
    wr(8'h10); idle(1); wr(8'h00); idle(2);
    // R4/R10/R11: reset, polarity, test loop
    wr(8'h01); idle(1);
    wr(8'h21); strobes(4, 0); strobes(2, 1);
    wr(8'hA1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, i[0], 0, 0, i[1]);
    wr(8'h01); wr(8'h00);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0, 0, i[0]);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom;
      int d = $urandom & 8'hFE;
      if (($urandom % 10) == 0) d |= 1;
      cyc((r % 8) == 0, ((r >> 4) % 8 == 0) ? 1 : 0, d, (r >> 8) % 3 != 0,
          (r >> 12) % 6 != 0, (r >> 16) % 24 == 0, (r >> 20) % 16 == 0, r[24]);
    end
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL R0 watchdog at cycle %0d: actual=running expected=finished", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule